// File: doc/BRIEF.md
# Two-Phase Handshake Elastic Queue

This block joins two pipeline stages with a small first-in first-out buffer. Both sides talk in transition-signalling style. A transfer is marked by one change of level on a request wire and one change of level on the matching acknowledge wire. There is no return-to-zero phase, so the direction of the change carries no meaning. All of this is modelled on one clock: every wire is sampled at the rising edge.

On the input side, the sender places a word on its data bus and flips its request wire. The queue stores the word and flips the acknowledge wire back as soon as it has room. On the output side, the queue presents the oldest stored word, flips its own request wire, and then waits for the receiver to flip the acknowledge wire before it offers the next word.

The storage depth is a parameter, with a default of two entries. The word being offered on the output side has already left the storage, so at most DEPTH plus one words are in flight inside the block.

Top module: `tpq_elastic_queue`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `in_ack` and `out_req` are low. With nothing stored, `out_req` stays low after reset.
- R2: A change of `in_req` in either direction counts as a new word. On acceptance, `in_ack` takes the same level as `in_req`. `in_ack` never changes while `in_req` equals `in_ack`.
- R3: When the storage has room, `in_ack` changes at the first rising edge at which `in_req` differs from `in_ack`.
- R4: While the storage holds DEPTH words, `in_ack` does not change. A pending request is acknowledged once an entry drains.
- R5: Words leave in the order they were accepted, each exactly once, whatever the stall patterns on the two sides.
- R6: `out_req` and `out_data` hold still from the moment `out_req` differs from `out_ack` until `out_ack` equals `out_req` again.
- R7: When the output side is idle (`out_req` equals `out_ack`) and a word is stored, `out_req` changes at the next rising edge and `out_data` carries that word. `out_req` never changes while nothing is stored.
- R8: `in_data` is captured at the edge that accepts the word. Later changes of `in_data` do not alter the word delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| in_req | input | 1 | Sender request; each change of level offers a word |
| in_data | input | WIDTH | Word offered by the sender |
| in_ack | output | 1 | Acknowledge to the sender; a change of level accepts a word |
| out_req | output | 1 | Request to the receiver; a change of level offers a word |
| out_data | output | WIDTH | Word offered to the receiver |
| out_ack | input | 1 | Receiver acknowledge; a change of level consumes the offered word |

## Verification
On every cycle, the assertions check the following:
- the acknowledge never flips without a pending request, and never while the storage is full;
- the output request and data stay frozen while a word is outstanding;
- no push reaches a full store, and no pop reaches an empty one;
- the output request never flips while nothing is stored.

Only the bench scenarios can show the end-to-end properties. These are:
- the exact one-cycle latencies on each side;
- that both polarities of transition are handled;
- that a held request is acknowledged once the receiver drains a word;
- that long random streams arrive in order with no loss or duplication.

// File: rtl/tpq_pkg.sv
package tpq_pkg;
  function automatic int idx_bits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tpq_store.sv
module tpq_store #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int AW = tpq_pkg::idx_bits(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  assign full  = (count == CAP);
  assign empty = (count == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4: storage never exceeds its capacity
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);
  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CAP);
  // R5: nothing is taken from an empty store
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);
endmodule

// File: rtl/tpq_in_side.sv
module tpq_in_side (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic room,
  output logic ack,
  output logic take
);
  logic ack_q;
  logic pending;

  assign pending = req ^ ack_q;
  assign take    = pending & room;
  assign ack     = ack_q;

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else if (take) ack_q <= ~ack_q;
  end

  // R2: no acknowledge change without an outstanding request
  a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
    (req == ack) |=> $stable(ack));
  // R4: a full store withholds the acknowledge
  a_r4_hold_when_full: assert property (@(posedge clk) disable iff (rst)
    !room |=> $stable(ack));
endmodule

// File: rtl/tpq_out_side.sv
module tpq_out_side #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             avail,
  input  logic [WIDTH-1:0] head,
  input  logic             ack,
  output logic             req,
  output logic [WIDTH-1:0] data,
  output logic             pop
);
  logic             req_q;
  logic [WIDTH-1:0] data_q;
  logic             idle;

  assign idle = (req_q == ack);
  assign pop  = idle & avail;
  assign req  = req_q;
  assign data = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      data_q <= '0;
    end else if (pop) begin
      req_q  <= ~req_q;
      data_q <= head;
    end
  end

  // R6: an outstanding word is frozen until acknowledged
  a_r6_req_waits: assert property (@(posedge clk) disable iff (rst)
    (req != ack) |=> $stable(req));
  a_r6_data_holds: assert property (@(posedge clk) disable iff (rst)
    (req != ack) |=> $stable(data));
  // R7: no offer without a stored word
  a_r7_req_needs_word: assert property (@(posedge clk) disable iff (rst)
    !avail |=> $stable(req));
endmodule

// File: rtl/tpq_elastic_queue.sv
module tpq_elastic_queue #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_req,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ack,
  output logic             out_req,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_ack
);
  logic             take, pop, full, empty;
  logic [WIDTH-1:0] head;

  tpq_in_side u_in (
    .clk  (clk),
    .rst  (rst),
    .req  (in_req),
    .room (!full),
    .ack  (in_ack),
    .take (take)
  );

  tpq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst       (rst),
    .push      (take),
    .push_data (in_data),
    .pop       (pop),
    .head      (head),
    .full      (full),
    .empty     (empty)
  );

  tpq_out_side #(.WIDTH(WIDTH)) u_out (
    .clk   (clk),
    .rst   (rst),
    .avail (!empty),
    .head  (head),
    .ack   (out_ack),
    .req   (out_req),
    .data  (out_data),
    .pop   (pop)
  );

  // R1: the wires on both sides come out of reset low
  a_r1_reset_low: assert property (@(posedge clk)
    $past(rst) |-> (!in_ack && !out_req));
endmodule

// File: tb/tpq_elastic_queue_tb.sv
module tpq_elastic_queue_tb;
  localparam int PERIOD = 10;
  localparam int W      = 16;
  localparam int DEPTH  = 2;
  localparam int NRAND  = 300;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_req = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ack;
  logic         out_req;
  logic [W-1:0] out_data;
  logic         out_ack = 1'b0;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;
  logic [W-1:0] sent [NRAND];
  logic [W-1:0] got  [NRAND];

  always #(PERIOD/2) clk = ~clk;

  tpq_elastic_queue #(.WIDTH(W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .in_req(in_req), .in_data(in_data), .in_ack(in_ack),
    .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic offer(input logic [W-1:0] d);
    in_data = d;
    in_req  = ~in_req;
  endtask

  task automatic wait_in_ack(input int lim, output bit ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (in_ack == in_req) begin ok = 1; return; end
    end
  endtask

  task automatic take_word(input int lim, output logic [W-1:0] d, output bit ok);
    ok = 0; d = '0;
    for (int i = 0; i < lim; i++) begin
      if (out_req != out_ack) begin
        d = out_data; ok = 1;
        out_ack = ~out_ack;
        @(negedge clk);
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; in_req = 1'b0; out_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ack == 1'b0, "R1 in_ack low in reset", in_ack, 0);
    chk(out_req == 1'b0, "R1 out_req low in reset", out_req, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(out_req == 1'b0, "R1 empty queue makes no offer", out_req, 0);
    chk(in_ack == 1'b0, "R1 in_ack stays low", in_ack, 0);
  endtask

  task automatic t_latency();
    logic [W-1:0] d; bit ok;
    offer(16'hA5A5);                         // rising transition
    @(negedge clk);
    chk(in_ack == 1'b1, "R3 ack one edge after rising req", in_ack, 1);
    @(negedge clk);
    chk(out_req == 1'b1, "R7 out_req flips next edge", out_req, 1);
    chk(out_data == 16'hA5A5, "R7 offered word", out_data, 16'hA5A5);
    take_word(5, d, ok);
    offer(16'h3C3C);                         // falling transition
    @(negedge clk);
    chk(in_ack == 1'b0, "R2 falling req accepted", in_ack, 0);
    @(negedge clk);
    chk(out_req == 1'b0, "R2 falling out_req offer", out_req, 0);
    chk(out_data == 16'h3C3C, "R2 second word", out_data, 16'h3C3C);
    take_word(5, d, ok);
    chk(ok && d == 16'h3C3C, "R2 second word taken", d, 16'h3C3C);
  endtask

  task automatic t_full();
    logic [W-1:0] d; bit ok;
    for (int i = 0; i < DEPTH + 1; i++) begin
      offer(W'(16'h1000 + i));
      wait_in_ack(10, ok);
      chk(ok, "R4 accepted before full", ok, 1);
    end
    offer(16'h1FFF);
    repeat (20) @(negedge clk);
    chk(in_ack != in_req, "R4 ack withheld while full", in_ack, ~in_req);
    chk(out_data == 16'h1000, "R6 data frozen while unacked", out_data, 16'h1000);
    take_word(5, d, ok);
    chk(ok && d == 16'h1000, "R5 first word out", d, 16'h1000);
    wait_in_ack(5, ok);
    chk(ok, "R4 pending req accepted after drain", ok, 1);
    for (int i = 1; i < DEPTH + 1; i++) begin
      take_word(10, d, ok);
      chk(ok && d == W'(16'h1000 + i), "R5 order after full", d, 16'h1000 + i);
    end
    take_word(10, d, ok);
    chk(ok && d == 16'h1FFF, "R5 held word delivered", d, 16'h1FFF);
  endtask

  task automatic t_data_hold();
    logic [W-1:0] d; bit ok;
    offer(16'h7E57);
    wait_in_ack(10, ok);
    in_data = 16'hDEAD;
    take_word(10, d, ok);
    chk(ok && d == 16'h7E57, "R8 word captured at acceptance", d, 16'h7E57);
  endtask

  task automatic t_random();
    int nrx = 0;
    int bad = 0;
    fork
      begin
        bit ok;
        for (int i = 0; i < NRAND; i++) begin
          sent[i] = W'($urandom);
          repeat ($urandom_range(0, 3)) @(negedge clk);
          offer(sent[i]);
          wait_in_ack(200, ok);
          if (!ok) chk(0, "R5 sender stuck", i, -1);
        end
      end
      begin
        for (int i = 0; i < NRAND; i++) begin
          logic [W-1:0] first; logic rq; int k;
          k = 0;
          while (out_req == out_ack && k < 400) begin @(negedge clk); k++; end
          first = out_data; rq = out_req;
          repeat ($urandom_range(0, 4)) @(negedge clk);
          if (out_data != first || out_req != rq) begin
            chk(0, "R6 offer changed before ack", out_data, first);
            bad++;
          end
          got[i] = out_data;
          nrx++;
          out_ack = ~out_ack;
          @(negedge clk);
        end
      end
    join
    chk(nrx == NRAND, "R5 word count", nrx, NRAND);
    for (int i = 0; i < NRAND; i++)
      if (got[i] != sent[i]) begin
        chk(0, "R5 random order", got[i], sent[i]);
        bad++;
      end
    chk(bad == 0, "R5 random stream intact", bad, 0);
    repeat (5) @(negedge clk);
    chk(out_req == out_ack, "R5 no duplicate offer", out_req, out_ack);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_latency();
    t_full();
    t_data_hold();
    t_random();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule